// File: doc/BRIEF.md
# Nested Loop Index Sequencer

This block produces, one tuple per clock, the index values that a set of up to three nested software loops would visit. Level 0 is the outermost loop and level `LEVELS-1` is the innermost. Each level holds a signed counter. The counter starts at its start value and moves by its step on each pass. It stops at the end value, which is inclusive and is found by an equality test. The start, step and end of every level are each chosen at build time from three sources: a constant, a signed input port, or the live value of an enclosing level's counter.

A one-cycle `go_i` pulse launches a run. The block then presents a new tuple on `idx_o` in every enabled cycle, with `qv_o` high. `ql_o` marks the final tuple. A `go_i` pulse during a run starts the run again from its start values. While `en_i` is low the block freezes and reports nothing.

Top module: `nested_loop_seq`

## Requirements
- R1: After reset the block waits: `qv_o` and `ql_o` are low until a `go_i` pulse is accepted.
- R2: A `go_i` pulse with `en_i` high while waiting makes `qv_o` high from the next cycle. In that cycle every counter holds its start value.
- R3: In each enabled counting cycle the innermost counter adds its step. When a counter equals its end value, it reloads its start on the next step and the next-outer level adds its own step in the same cycle. Outer levels hold while any inner level is short of its end.
- R4: `ql_o` is high exactly in the cycle when every counter equals its end value. On the following cycle `qv_o` is low unless `go_i` was high. End values are inclusive, so every level runs at least once.
- R5: A `go_i` pulse during counting keeps the block counting and reloads every counter with its start value on the next cycle.
- R6: While `en_i` is low, `qv_o` and `ql_o` are low, no counter or state changes, and `go_i` has no effect.
- R7: A bound taken from an enclosing counter uses that counter's value from the same cycle. A start reload therefore sees the outer counter's updated value.
- R8: Port bounds are `PW`-bit two's-complement values, sign-extended to `CW` bits. Counters and negative steps are signed, so a level can count downward.
- R9: A `go_i` pulse in the `ql_o` cycle starts a new run with no waiting cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Start / restart pulse |
| en_i | input | 1 | Enable; low freezes the block |
| start_port_i | input | LEVELS*PW | Per-level signed start value, used where the start source is a port |
| step_port_i | input | LEVELS*PW | Per-level signed step value, used where the step source is a port |
| end_port_i | input | LEVELS*PW | Per-level signed end value, used where the end source is a port |
| qv_o | output | 1 | Tuple on `idx_o` is valid |
| ql_o | output | 1 | Tuple on `idx_o` is the final one |
| idx_o | output | LEVELS*CW | Per-level signed counter values, level 0 outermost |

## Verification
The bench builds the block with `LEVELS=3`, `CW=8` and `PW=4`. The outer level takes its start and end from ports. The middle level starts at the outer index and takes its step from a port. The inner level counts down from a constant 3 to the middle index. This one configuration uses every source kind and a negative step, and it sign-extends negative 4-bit port values. The bench sweeps every outer start/end pair from -2 to 3. It adds enable gaps that carry ignored go pulses, restarts in mid-run and on the final tuple, and the single-tuple run where every level starts at its end.

// File: rtl/nls_pkg.sv
package nls_pkg;

    localparam int MAX_LEVELS = 3;

    typedef enum logic [1:0] {
        SRC_CONST = 2'd0,
        SRC_PORT  = 2'd1,
        SRC_OUTER = 2'd2
    } nls_src_e;

    typedef enum logic {
        ST_WAIT  = 1'b0,
        ST_COUNT = 1'b1
    } nls_state_e;

endpackage

// File: rtl/nls_field_sel.sv
module nls_field_sel
    import nls_pkg::*;
#(
    parameter int       LEVELS = 3,
    parameter int       CW     = 16,
    parameter int       PW     = 8,
    parameter int       LEVEL  = 0,
    parameter nls_src_e SRC    = SRC_CONST,
    parameter int       VAL    = 0,
    parameter int       REF    = 0
) (
    input  logic [LEVELS-1:0][CW-1:0] outer_i,
    input  logic [PW-1:0]             port_i,
    output logic [CW-1:0]             val_o
);

    // Only a strictly enclosing level is a legal reference.
    localparam bit REF_OK = (REF >= 0) && (REF < LEVEL);

    generate
        if (SRC == SRC_PORT) begin : g_port
            assign val_o = CW'($signed(port_i));
        end else if (SRC == SRC_OUTER && REF_OK) begin : g_outer
            assign val_o = outer_i[REF];
        end else begin : g_const
            assign val_o = CW'(VAL);
        end
    endgenerate

    logic unused_sel;
    assign unused_sel = ^{outer_i, port_i};

endmodule

// File: rtl/nls_ctrl.sv
module nls_ctrl
    import nls_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic go_i,
    input  logic en_i,
    input  logic done_i,
    output logic counting_o,
    output logic load_o,
    output logic step_o
);

    nls_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (en_i) begin
            if (go_i) begin
                state_d = ST_COUNT;
            end else if (state_q == ST_COUNT && done_i) begin
                state_d = ST_WAIT;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    assign counting_o = (state_q == ST_COUNT);
    assign load_o     = en_i & go_i;
    assign step_o     = en_i & counting_o & ~go_i & ~done_i;

    // R2
    go_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && go_i) |=> (state_q == ST_COUNT));

    // R4
    last_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_COUNT && en_i && done_i && !go_i) |=> (state_q == ST_WAIT));

    // R6
    en_freeze_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(state_q));

endmodule

// File: rtl/nested_loop_seq.sv
module nested_loop_seq
    import nls_pkg::*;
#(
    parameter int       LEVELS = 2,
    parameter int       CW     = 16,
    parameter int       PW     = 8,
    parameter nls_src_e START_SRC [MAX_LEVELS] = '{SRC_CONST, SRC_CONST, SRC_CONST},
    parameter int       START_VAL [MAX_LEVELS] = '{0, 0, 0},
    parameter int       START_REF [MAX_LEVELS] = '{0, 0, 0},
    parameter nls_src_e STEP_SRC  [MAX_LEVELS] = '{SRC_CONST, SRC_CONST, SRC_CONST},
    parameter int       STEP_VAL  [MAX_LEVELS] = '{1, 1, 1},
    parameter int       STEP_REF  [MAX_LEVELS] = '{0, 0, 0},
    parameter nls_src_e END_SRC   [MAX_LEVELS] = '{SRC_CONST, SRC_CONST, SRC_CONST},
    parameter int       END_VAL   [MAX_LEVELS] = '{3, 3, 3},
    parameter int       END_REF   [MAX_LEVELS] = '{0, 0, 0}
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      go_i,
    input  logic                      en_i,
    input  logic [LEVELS-1:0][PW-1:0] start_port_i,
    input  logic [LEVELS-1:0][PW-1:0] step_port_i,
    input  logic [LEVELS-1:0][PW-1:0] end_port_i,
    output logic                      qv_o,
    output logic                      ql_o,
    output logic [LEVELS-1:0][CW-1:0] idx_o
);

    localparam int INNER = LEVELS - 1;

    typedef struct packed {
        logic [LEVELS-1:0][CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [LEVELS-1:0][CW-1:0] start_fix;
    logic [LEVELS-1:0][CW-1:0] step_v;
    logic [LEVELS-1:0][CW-1:0] end_v;
    logic [LEVELS-1:0]         at_end;
    logic [LEVELS-1:0]         carry;
    logic                      done;
    logic                      counting;
    logic                      load;
    logic                      step;

    // Per-level bound selection; step and end read the current counters.
    generate
        for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
            nls_field_sel #(
                .LEVELS (LEVELS), .CW (CW), .PW (PW), .LEVEL (g),
                .SRC (START_SRC[g]), .VAL (START_VAL[g]), .REF (START_REF[g])
            ) u_start (
                .outer_i (seq_q.cnt),
                .port_i  (start_port_i[g]),
                .val_o   (start_fix[g])
            );

            nls_field_sel #(
                .LEVELS (LEVELS), .CW (CW), .PW (PW), .LEVEL (g),
                .SRC (STEP_SRC[g]), .VAL (STEP_VAL[g]), .REF (STEP_REF[g])
            ) u_step (
                .outer_i (seq_q.cnt),
                .port_i  (step_port_i[g]),
                .val_o   (step_v[g])
            );

            nls_field_sel #(
                .LEVELS (LEVELS), .CW (CW), .PW (PW), .LEVEL (g),
                .SRC (END_SRC[g]), .VAL (END_VAL[g]), .REF (END_REF[g])
            ) u_end (
                .outer_i (seq_q.cnt),
                .port_i  (end_port_i[g]),
                .val_o   (end_v[g])
            );

            assign at_end[g] = (seq_q.cnt[g] == end_v[g]);
        end
    endgenerate

    // A level moves when every level inside it sits at its end.
    always_comb begin
        carry[INNER] = 1'b1;
        for (int l = INNER - 1; l >= 0; l--) begin
            carry[l] = carry[l+1] & at_end[l+1];
        end
    end

    assign done = carry[0] & at_end[0];

    nls_ctrl u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .go_i       (go_i),
        .en_i       (en_i),
        .done_i     (done),
        .counting_o (counting),
        .load_o     (load),
        .step_o     (step)
    );

    // Outer to inner, so a start tied to an outer level sees its new value.
    always_comb begin
        logic [CW-1:0] st;
        seq_d = seq_q;
        for (int l = 0; l < LEVELS; l++) begin
            st = start_fix[l];
            for (int r = 0; r < l; r++) begin
                if (START_SRC[l] == SRC_OUTER && START_REF[l] == r) begin
                    st = seq_d.cnt[r];
                end
            end
            if (load) begin
                seq_d.cnt[l] = st;
            end else if (step && carry[l]) begin
                if (at_end[l]) begin
                    seq_d.cnt[l] = st;
                end else begin
                    seq_d.cnt[l] = seq_q.cnt[l] + step_v[l];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign qv_o  = counting & en_i;
    assign ql_o  = counting & en_i & done;
    assign idx_o = seq_q.cnt;

    // R6
    en_freeze_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(seq_q.cnt));

    // R3
    inner_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (qv_o && !go_i && !at_end[INNER])
        |=> (seq_q.cnt[INNER] == $past(seq_q.cnt[INNER] + step_v[INNER])));

    // R5
    restart_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (qv_o && go_i) |=> counting);

    generate
        if (LEVELS > 1) begin : g_outer_chk
            // R3
            outer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (qv_o && !go_i && !at_end[INNER])
                |=> $stable(seq_q.cnt[LEVELS-2:0]));
        end
    endgenerate

endmodule

// File: tb/nested_loop_seq_tb.sv
module nested_loop_seq_tb;
    import nls_pkg::*;

    localparam int L  = 3;
    localparam int CW = 8;
    localparam int PW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic en = 1'b0;
    logic [L-1:0][PW-1:0] sp = '0;
    logic [L-1:0][PW-1:0] pp = '0;
    logic [L-1:0][PW-1:0] ep = '0;
    logic qv, ql;
    logic [L-1:0][CW-1:0] idx;

    int n_run  = 0;
    int n_fail = 0;
    int ei [0:255];
    int ej [0:255];
    int ek [0:255];
    int n_exp = 0;

    always #5 clk = ~clk;

    nested_loop_seq #(
        .LEVELS (L), .CW (CW), .PW (PW),
        .START_SRC ('{SRC_PORT, SRC_OUTER, SRC_CONST}),
        .START_VAL ('{0, 0, 3}),
        .START_REF ('{0, 0, 0}),
        .STEP_SRC  ('{SRC_CONST, SRC_PORT, SRC_CONST}),
        .STEP_VAL  ('{1, 0, -1}),
        .STEP_REF  ('{0, 0, 0}),
        .END_SRC   ('{SRC_PORT, SRC_PORT, SRC_OUTER}),
        .END_VAL   ('{0, 0, 0}),
        .END_REF   ('{0, 0, 1})
    ) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .go_i         (go),
        .en_i         (en),
        .start_port_i (sp),
        .step_port_i  (pp),
        .end_port_i   (ep),
        .qv_o         (qv),
        .ql_o         (ql),
        .idx_o        (idx)
    );

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic check(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(logic e, logic g);
        @(negedge clk);
        en = e;
        go = g;
        #1;
    endtask

    // Reference: for i=s0..e0 / for j=i..3 / for k=3 down to j (inclusive).
    task automatic build(int s0, int e0);
        int i, j, k;
        n_exp = 0;
        i = s0;
        forever begin
            j = i;
            forever begin
                k = 3;
                forever begin
                    ei[n_exp] = i; ej[n_exp] = j; ek[n_exp] = k;
                    n_exp++;
                    if (k == j) break;
                    k--;
                end
                if (j == 3) break;
                j++;
            end
            if (i == e0) break;
            i++;
        end
    endtask

    task automatic check_tuple(string req, int n);
        check(req, "qv", int'(qv), 1);
        check(req, "idx0", int'($signed(idx[0])), ei[n]);
        check(req, "idx1", int'($signed(idx[1])), ej[n]);
        check(req, "idx2", int'($signed(idx[2])), ek[n]);
        check("R4", "ql", int'(ql), (n == n_exp - 1) ? 1 : 0);
    endtask

    task automatic set_ports(int s0, int e0);
        sp[0] = PW'(s0);
        ep[0] = PW'(e0);
        pp[1] = PW'(1);
        ep[1] = PW'(3);
    endtask

    // Full run; optional enable gaps carrying ignored go pulses.
    task automatic run(int s0, int e0, bit gaps);
        set_ports(s0, e0);
        build(s0, e0);
        cyc(1'b1, 1'b1);
        check("R2", "qv before start", int'(qv), 0);
        for (int n = 0; n < n_exp; n++) begin
            if (gaps && (n % 4 == 2)) begin
                cyc(1'b0, 1'b1);
                check("R6", "qv en low", int'(qv), 0);
                check("R6", "ql en low", int'(ql), 0);
            end
            cyc(1'b1, 1'b0);
            check_tuple((n == 0) ? "R8" : "R7", n);
        end
        cyc(1'b1, 1'b0);
        check("R4", "qv after last", int'(qv), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R4 watchdog: actual=running expected=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cyc(1'b1, 1'b0);
        check("R1", "qv after reset", int'(qv), 0);
        check("R1", "ql after reset", int'(ql), 0);

        // R6: go while disabled is ignored
        set_ports(0, 0);
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b0);
        check("R6", "qv after masked go", int'(qv), 0);

        // R3 R4 R7 R8: sweep of every outer start/end pair
        for (int s0 = -2; s0 <= 3; s0++) begin
            for (int e0 = s0; e0 <= 3; e0++) begin
                run(s0, e0, ((s0 + e0) % 2) != 0);
            end
        end

        // R4: single-tuple run, every level at its end from the start
        set_ports(3, 3);
        build(3, 3);
        cyc(1'b1, 1'b1);
        cyc(1'b1, 1'b0);
        check("R4", "single ql", int'(ql), 1);
        check_tuple("R4", 0);
        cyc(1'b1, 1'b0);
        check("R4", "single exit", int'(qv), 0);

        // R5: restart in mid-run
        set_ports(0, 1);
        build(0, 1);
        cyc(1'b1, 1'b1);
        for (int n = 0; n < 5; n++) begin
            cyc(1'b1, 1'b0);
            check_tuple("R3", n);
        end
        cyc(1'b1, 1'b1);
        check_tuple("R5", 5);
        for (int n = 0; n < n_exp; n++) begin
            cyc(1'b1, 1'b0);
            check_tuple("R5", n);
        end
        cyc(1'b1, 1'b0);
        check("R5", "qv after rerun", int'(qv), 0);

        // R9: go on the final tuple runs straight into a new run
        set_ports(2, 3);
        build(2, 3);
        cyc(1'b1, 1'b1);
        for (int n = 0; n < n_exp - 1; n++) begin
            cyc(1'b1, 1'b0);
            check_tuple("R3", n);
        end
        cyc(1'b1, 1'b1);
        check("R9", "ql with go", int'(ql), 1);
        for (int n = 0; n < n_exp; n++) begin
            cyc(1'b1, 1'b0);
            check_tuple("R9", n);
        end
        cyc(1'b1, 1'b0);
        check("R9", "qv after chained run", int'(qv), 0);

        finish_up();
    end

endmodule